// File: doc/BRIEF.md
# Lockable Control Word with Key Gate

This block is a small memory-mapped register bank. It holds a 32-bit control word, a sticky per-group freeze register and a write-only key register, all reached through one word-wide request port. Software freezes groups of control fields by setting bits in the freeze register. A frozen group keeps its value through later control writes, and only a reset releases it. The key register opens or closes the register window. A write of the correct key also forces some control fields to their enabled state, and a write of any other value clears those fields and shuts the window.

The current control word is driven out on `ctrl_o` for the logic that it governs. A separate flag reports when the 3-bit cipher-enable field holds a value that is neither all-zero nor all-one. The block does not act on that flag. It only reports it.

Top module: `ctl_lock_regs`

## Requirements
- R1: After reset, the control word is 0x0C006000 (bits 27, 26, 14 and 13 set), the freeze register is 0, the window is open and `cipher_mix_o` is low.
- R2: The freeze register sits at offset 0x04. A write ORs bits 4:0 of the data into the stored value, so no bit can be cleared, and a read returns the stored value in bits 4:0 with zeros above.
- R3: Each freeze bit guards one group: bit 0 guards control bits 6:0, bit 1 guards bit 7, bit 2 guards bit 8, bit 3 guards the cipher-enable field 11:9, and bit 4 guards bit 12.
- R4: A write to the control word at offset 0x00 keeps the old value of every guarded field and takes the written value everywhere else. Bit 31 always reads 0.
- R5: A write of 0x757BDF0D to the key register at offset 0x08 sets control bit 27 and all of field 11:9, even when that field is frozen, and it opens the window.
- R6: A write of any other value to the key register clears control bit 27 and field 11:9, and it closes the window.
- R7: While the window is closed, every read returns 0 and writes to the control word and the freeze register are dropped. Key writes still take effect.
- R8: `cipher_mix_o` is high exactly when the stored field 11:9 is neither 000 nor 111.
- R9: Unaligned offsets, unmapped offsets and the key register all read as 0. Writes to unaligned or unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational on the request |
| ctrl_o | output | 32 | Current control word |
| win_open_o | output | 1 | Register window open |
| cipher_mix_o | output | 1 | Cipher-enable field inconsistent |

## Verification
A control write can touch frozen and free fields in the same cycle. The bench provokes this by writing random data while random subsets of freeze bits are set, and it judges the result against a model that merges the old and new values under the group masks.

A key write can also force field 11:9 while that field is frozen. The good-key case is driven with freeze bit 3 set, and the forced value is expected to override the freeze.

// File: rtl/ctl_lock_pkg.sv
package ctl_lock_pkg;
  localparam int unsigned DW   = 32;
  localparam int unsigned NGRP = 5;
  localparam logic [DW-1:0] CTRL_RST   = 32'h0C00_6000;
  localparam logic [DW-1:0] KEY_VAL    = 32'h757B_DF0D;
  localparam logic [DW-1:0] FORCE_MASK = 32'h0800_0E00;
  localparam logic [DW-1:0] WR_MASK    = 32'h7FFF_FFFF;

  typedef enum logic [1:0] {SEL_NONE, SEL_CTRL, SEL_LOCK, SEL_KEY} sel_e;

  function automatic logic [DW-1:0] grp_mask(input int unsigned g);
    case (g)
      0:       grp_mask = 32'h0000_007F;
      1:       grp_mask = 32'h0000_0080;
      2:       grp_mask = 32'h0000_0100;
      3:       grp_mask = 32'h0000_0E00;
      4:       grp_mask = 32'h0000_1000;
      default: grp_mask = '0;
    endcase
  endfunction
endpackage

// File: rtl/ctl_lock_decode.sv
module ctl_lock_decode #(
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned CTRL_OFF = 0,
  parameter int unsigned LOCK_OFF = 4,
  parameter int unsigned KEY_OFF  = 8
) (
  input  logic [ADDR_W-1:0]     addr_i,
  output ctl_lock_pkg::sel_e    sel_o
);
  import ctl_lock_pkg::*;
  always_comb begin
    sel_o = SEL_NONE;
    if (addr_i[1:0] == 2'b00) begin
      if (addr_i == ADDR_W'(CTRL_OFF))      sel_o = SEL_CTRL;
      else if (addr_i == ADDR_W'(LOCK_OFF)) sel_o = SEL_LOCK;
      else if (addr_i == ADDR_W'(KEY_OFF))  sel_o = SEL_KEY;
    end
  end
endmodule

// File: rtl/ctl_lock_freeze.sv
module ctl_lock_freeze #(
  parameter int unsigned NGRP = ctl_lock_pkg::NGRP,
  parameter int unsigned DW   = ctl_lock_pkg::DW
) (
  input  logic [NGRP-1:0] lock_i,
  output logic [DW-1:0]   frz_o
);
  logic [NGRP-1:0][DW-1:0] part;
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign part[g] = lock_i[g] ? ctl_lock_pkg::grp_mask(g) : '0;
  end
  always_comb begin
    frz_o = '0;
    for (int i = 0; i < NGRP; i++) frz_o |= part[i];
  end
endmodule

// File: rtl/ctl_lock_ctrl.sv
module ctl_lock_ctrl #(
  parameter int unsigned DW = ctl_lock_pkg::DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          key_wr_i,
  input  logic          key_ok_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] frz_i,
  output logic [DW-1:0] ctrl_o,
  output logic          mix_o
);
  import ctl_lock_pkg::*;
  logic [DW-1:0] ctrl_q, ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (key_wr_i) ctrl_d = key_ok_i ? (ctrl_q | FORCE_MASK) : (ctrl_q & ~FORCE_MASK);
    else if (wr_i) ctrl_d = ((ctrl_q & frz_i) | (wdata_i & ~frz_i)) & WR_MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= CTRL_RST;
    else         ctrl_q <= ctrl_d;
  end

  assign ctrl_o = ctrl_q;
  assign mix_o  = (ctrl_q[11:9] != 3'b000) && (ctrl_q[11:9] != 3'b111);
endmodule

// File: rtl/ctl_lock_regs.sv
module ctl_lock_regs #(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [31:0]       ctrl_o,
  output logic              win_open_o,
  output logic              cipher_mix_o
);
  import ctl_lock_pkg::*;

  sel_e            sel;
  logic [NGRP-1:0] lock_q;
  logic            win_q;
  logic [DW-1:0]   frz_mask;
  logic            wr, ctrl_we, lock_we, key_we, key_ok;

  ctl_lock_decode #(.ADDR_W(ADDR_W)) i_dec (.addr_i(addr_i), .sel_o(sel));

  assign wr      = req_i && we_i;
  assign ctrl_we = wr && win_q && (sel == SEL_CTRL);
  assign lock_we = wr && win_q && (sel == SEL_LOCK);
  assign key_we  = wr && (sel == SEL_KEY);
  assign key_ok  = (wdata_i == KEY_VAL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= '0;
      win_q  <= 1'b1;
    end else begin
      if (lock_we) lock_q <= lock_q | wdata_i[NGRP-1:0];
      if (key_we)  win_q  <= key_ok;
    end
  end

  ctl_lock_freeze i_frz (.lock_i(lock_q), .frz_o(frz_mask));

  ctl_lock_ctrl i_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(ctrl_we), .key_wr_i(key_we),
    .key_ok_i(key_ok), .wdata_i(wdata_i), .frz_i(frz_mask),
    .ctrl_o(ctrl_o), .mix_o(cipher_mix_o)
  );

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i && win_q) begin
      case (sel)
        SEL_CTRL: rdata_o = ctrl_o;
        SEL_LOCK: rdata_o = {{(DW-NGRP){1'b0}}, lock_q};
        default:  rdata_o = '0;
      endcase
    end
  end

  assign win_open_o = win_q;
endmodule

// File: rtl/ctl_lock_chk.sv
module ctl_lock_chk #(
  parameter int unsigned ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic [31:0]       rdata_o,
  input logic [31:0]       ctrl_o,
  input logic              win_open_o,
  input logic              cipher_mix_o,
  input logic [4:0]        lock_q,
  input logic [31:0]       frz_mask
);
  logic primed;
  logic key_wr;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) primed <= 1'b0;
    else         primed <= 1'b1;
  end
  assign key_wr = req_i && we_i && (addr_i == ADDR_W'(8));

  // R2
  lock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed |-> (($past(lock_q) & ~lock_q) == 5'b0));
  // R3
  frozen_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed && !$past(key_wr)) |-> (((ctrl_o ^ $past(ctrl_o)) & $past(frz_mask)) == 32'h0));
  // R4
  top_bit_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[31] == 1'b0);
  // R5
  good_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_wr && wdata_i == 32'h757B_DF0D) |=> (win_open_o && ctrl_o[27] && ctrl_o[11:9] == 3'b111));
  // R6
  bad_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_wr && wdata_i != 32'h757B_DF0D) |=> (!win_open_o && !ctrl_o[27] && ctrl_o[11:9] == 3'b000));
  // R7
  closed_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !win_open_o) |-> (rdata_o == 32'h0));
  // R8
  mix_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed && !$stable(cipher_mix_o)) |-> $past(req_i && we_i));
endmodule

bind ctl_lock_regs ctl_lock_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .ctrl_o(ctrl_o), .win_open_o(win_open_o),
  .cipher_mix_o(cipher_mix_o), .lock_q(lock_q), .frz_mask(frz_mask)
);

// File: tb/test_ctl_lock_regs.sv
module test_ctl_lock_regs;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam logic [31:0] KEY = 32'h757B_DF0D;

  logic clk = 0, rst_ni = 0, req = 0, we = 0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata, ctrl;
  logic win, mix;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] m_ctrl, m_lock;
  bit m_win;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctl_lock_regs #(.ADDR_W(AW)) i_ctl_lock_regs (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .ctrl_o(ctrl), .win_open_o(win),
    .cipher_mix_o(mix));

  function automatic logic [31:0] grp(input logic [31:0] lk);
    logic [31:0] m = 0;
    if (lk[0]) m |= 32'h7F;
    if (lk[1]) m |= 32'h80;
    if (lk[2]) m |= 32'h100;
    if (lk[3]) m |= 32'hE00;
    if (lk[4]) m |= 32'h1000;
    return m;
  endfunction

  function automatic bit mixed(input logic [31:0] c);
    return c[11:9] != 3'b000 && c[11:9] != 3'b111;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic model_reset();
    m_ctrl = 32'h0C00_6000; m_lock = 0; m_win = 1;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 0; req = 0; we = 0;
    model_reset();
    @(negedge clk); rst_ni = 1;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    logic [31:0] f;
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
    if (a == 8) begin
      m_win = (d == KEY);
      m_ctrl = m_win ? (m_ctrl | 32'h0800_0E00) : (m_ctrl & ~32'h0800_0E00);
    end else if (m_win && a == 0) begin
      f = grp(m_lock);
      m_ctrl = ((m_ctrl & f) | (d & ~f)) & 32'h7FFF_FFFF;
    end else if (m_win && a == 4) begin
      m_lock = m_lock | (d & 32'h1F);
    end
  endtask

  task automatic rd_chk(input string tag, input logic [AW-1:0] a);
    logic [31:0] e;
    @(negedge clk); req = 1; we = 0; addr = a;
    #1;
    e = !m_win ? 0 : (a == 0) ? m_ctrl : (a == 4) ? m_lock : 0;
    chk(tag, rdata, e);
    req = 0;
  endtask

  task automatic out_chk(input string tag);
    #1;
    chk({tag, " ctrl_o"}, ctrl, m_ctrl);
    chk({tag, " win"}, {31'b0, win}, {31'b0, m_win});
    chk({tag, " R8 mix"}, {31'b0, mix}, {31'b0, mixed(m_ctrl)});
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    logic [AW-1:0] addrs [6];
    logic [AW-1:0] a;
    int r;
    addrs = '{6'h00, 6'h04, 6'h08, 6'h0C, 6'h01, 6'h3C};
    void'($urandom(32'h1234));
    model_reset();
    repeat (2) @(negedge clk);
    rst_ni = 1;
    // R1 reset state
    out_chk("R1");
    rd_chk("R1 ctrl", 0);
    rd_chk("R1 lock", 4);
    // R2 sticky OR, upper bits dropped
    wr(4, 32'h1); wr(4, 32'h0); rd_chk("R2 or", 4);
    wr(4, 32'hFFFF_FFE0); rd_chk("R2 upper", 4);
    // R3 R4 group 0 frozen, others free, bit 31 dropped
    wr(0, 32'hFFFF_FFFF); out_chk("R3 R4 grp0");
    // R8 inconsistent field
    wr(0, 32'h0000_0200); out_chk("R8 set");
    // R3 freeze field 11:9, then R5 good key overrides it
    wr(4, 32'h8); wr(0, 32'h0); out_chk("R3 grp3");
    wr(8, KEY); out_chk("R5 key");
    // R6 bad key, R7 closed window
    wr(8, 32'h0); out_chk("R6 bad");
    rd_chk("R7 read", 0);
    wr(0, 32'h1234_5678); wr(4, 32'h1F); out_chk("R7 drop");
    wr(8, KEY); out_chk("R7 recover");
    rd_chk("R7 lock kept", 4);
    // R9 unmapped / unaligned
    wr(6'h0C, 32'hFFFF_FFFF); wr(6'h01, 32'h0); out_chk("R9 wr");
    rd_chk("R9 unaligned", 6'h01);
    rd_chk("R9 key", 8);
    rd_chk("R9 unmapped", 6'h3C);
    // random phase, reset every 100 operations
    for (int i = 0; i < 400; i++) begin
      if (i % 100 == 0) begin do_reset(); out_chk("R1 rnd"); end
      r = $urandom_range(0, 15);
      if (r < 8)       wr(0, $urandom());
      else if (r == 8) wr(4, 32'(1) << $urandom_range(0, 4));
      else if (r == 9) wr(8, ($urandom_range(0, 1) != 0) ? KEY : $urandom());
      else begin
        a = addrs[$urandom_range(0, 5)];
        if (r < 13) wr(a, $urandom());
        else rd_chk("R9 R7 rnd read", a);
      end
      out_chk("R4 R3 rnd");
      if (i % 7 == 0) rd_chk("R2 rnd lock", 4);
    end
    summary();
  end
endmodule